// File: doc/BRIEF.md
# Deferred-Destination Pipelined Load Unit

This block issues memory reads in which the target register is named late. Each load presents one full address. The destination field that comes with that same load does not name where its own data goes. It names where the data of the load issued two loads earlier is written. While a load is in flight it therefore holds no register, and software can keep using that register until the data is retired. The unit keeps the outstanding loads in a two-entry ordered queue. It captures in-order memory responses into that queue and writes retired data through a single register-file write port.

Any stride, gather or scatter pattern comes from the caller, because every address is supplied explicitly. A drain command retires queued data into supplied registers without starting a new read. A flush empties the queue, and the loads that were still in flight at that moment are forgotten.

Top module: `dd_load_unit`

## Requirements
- R1: After reset `issue_ready_o` is high, and `drain_ready_o`, `mem_req_valid_o` and `rf_we_o` are low.
- R2: An issue is accepted in a cycle where `issue_valid_i` and `issue_ready_o` are both high. In that same cycle `mem_req_valid_o` is high and `mem_req_addr_o` equals `issue_addr_i`. In every other cycle `mem_req_valid_o` is low.
- R3: The first two issues accepted after reset or flush cause no register write. Their `issue_dest_i` values are ignored.
- R4: An issue accepted while two loads are queued retires the oldest load. The clock edge after acceptance raises `rf_we_o` for one cycle, with `rf_waddr_o` equal to that issue's destination and `rf_wdata_o` equal to the oldest load's data. The Nth load's destination thus receives the data of load N-2.
- R5: No more than two loads are ever queued.
- R6: While two loads are queued and the oldest has no data yet, `issue_ready_o` is low. With fewer than two queued, it is high unless R9 applies.
- R7: `drain_ready_o` is high only when the queue is not empty, the oldest entry has its data, `issue_valid_i` is low and `flush_i` is low. A drain accepted with `drain_valid_i` retires the oldest load into `drain_dest_i`, with the write timed as in R4. A drain request while `drain_ready_o` is low produces no write.
- R8: `flush_i` empties the queue in one cycle, and no issue is accepted in that cycle. Data returning later for loads that were in flight at the flush is never written.
- R9: While responses to flushed loads are still outstanding, `issue_ready_o` stays low.
- R10: Memory responses arrive in request order. Each one fills the oldest queued entry that is still waiting, and any response latency gives the same register contents.
- R11: Data is bound to the address its load supplied, for any sequence of addresses: repeated, descending or scattered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Empty the queue and forget in-flight loads |
| issue_valid_i | input | 1 | A load is presented |
| issue_addr_i | input | ADDR_W | Address of the presented load |
| issue_dest_i | input | REG_AW | Register for the load two issues older |
| issue_ready_o | output | 1 | The presented load can be taken this cycle |
| drain_valid_i | input | 1 | Retire the oldest load without a new read |
| drain_dest_i | input | REG_AW | Register for the drained data |
| drain_ready_o | output | 1 | A drain can be taken this cycle |
| mem_req_valid_o | output | 1 | Read request to memory |
| mem_req_addr_o | output | ADDR_W | Read request address |
| mem_rsp_valid_i | input | 1 | Read data returned, in request order |
| mem_rsp_data_i | input | DATA_W | Returned read data |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | REG_AW | Register-file write index |
| rf_wdata_o | output | DATA_W | Register-file write data |

## Verification
The assertions check some rules on every cycle:
- the queue never holds more than two loads;
- a retirement never happens without data at the head;
- no issue is taken while the oldest entry is still waiting or while dropped responses are pending;
- a flush always leaves the queue empty;
- a response never arrives with nothing waiting for it.

Only the bench scenarios can show the end-to-end binding of each address's data to the register named two loads later. The scenarios cover random response latencies, strided and scattered address patterns, drains, and flushes with reads still in flight. They also show that the first two destinations after an empty start are really ignored.

// File: rtl/dd_load_pkg.sv
package dd_load_pkg;

   // Source of a retirement on the register-file write port
   typedef enum logic [1:0] {
      RET_NONE  = 2'd0,
      RET_ISSUE = 2'd1,
      RET_DRAIN = 2'd2
   } ret_src_e;

   // Width of a counter that must reach n
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/dd_load_queue.sv
module dd_load_queue
   import dd_load_pkg::*;
#(
   parameter int unsigned DEPTH  = 2,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CW    = cnt_width(DEPTH),
   localparam int unsigned IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              rsp_valid_i,
   input  logic [DATA_W-1:0] rsp_data_i,
   output logic [CW-1:0]     count_o,
   output logic              head_ready_o,
   output logic [DATA_W-1:0] head_data_o,
   output logic              drop_busy_o
);

   logic [IW-1:0]     head_q;
   logic [CW-1:0]     count_q, filled_q, drop_q;
   logic [CW-1:0]     count_d, filled_d, drop_d;
   logic [IW-1:0]     head_d;
   logic [DEPTH-1:0]  rdy_q, rdy_d;
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [DATA_W-1:0] data_d [DEPTH];
   logic [IW-1:0]     tail_idx, fill_idx;
   logic [CW-1:0]     unfilled;
   logic              rsp_live, rsp_drop;

   function automatic logic [IW-1:0] wrap_add(input logic [IW-1:0] p,
                                              input logic [CW-1:0] k);
      int unsigned s;
      s = int'(p) + int'(k);
      if (s >= DEPTH) s = s - DEPTH;
      return IW'(s);
   endfunction

   assign tail_idx = wrap_add(head_q, count_q);
   assign fill_idx = wrap_add(head_q, filled_q);
   assign unfilled = count_q - filled_q;
   assign rsp_drop = rsp_valid_i && (drop_q != '0);
   assign rsp_live = rsp_valid_i && (drop_q == '0);

   // Per-entry next state: clear on push or pop, fill on a live response
   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      logic clr, fill;
      assign clr  = (push_i && tail_idx == IW'(e)) || (pop_i && head_q == IW'(e));
      assign fill = rsp_live && fill_idx == IW'(e);
      assign rdy_d[e]  = flush_i ? 1'b0 : (fill ? 1'b1 : (clr ? 1'b0 : rdy_q[e]));
      assign data_d[e] = (fill && !flush_i) ? rsp_data_i : data_q[e];
   end

   always_comb begin
      count_d  = count_q + CW'(push_i) - CW'(pop_i);
      filled_d = filled_q + CW'(rsp_live) - CW'(pop_i);
      head_d   = pop_i ? wrap_add(head_q, CW'(1)) : head_q;
      drop_d   = drop_q - CW'(rsp_drop);
      if (flush_i) begin
         count_d  = '0;
         filled_d = '0;
         head_d   = '0;
         drop_d   = drop_d + unfilled - CW'(rsp_live);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q   <= '0;
         count_q  <= '0;
         filled_q <= '0;
         drop_q   <= '0;
         rdy_q    <= '0;
         for (int i = 0; i < DEPTH; i++) data_q[i] <= '0;
      end else begin
         head_q   <= head_d;
         count_q  <= count_d;
         filled_q <= filled_d;
         drop_q   <= drop_d;
         rdy_q    <= rdy_d;
         for (int i = 0; i < DEPTH; i++) data_q[i] <= data_d[i];
      end
   end

   assign count_o      = count_q;
   assign head_ready_o = rdy_q[head_q];
   assign head_data_o  = data_q[head_q];
   assign drop_busy_o  = (drop_q != '0);

   // R5: occupancy never exceeds the depth
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));
   // R10: filled entries are a prefix of the occupied ones
   a_r10_fill_within_count: assert property (@(posedge clk) disable iff (!rst_n)
      filled_q <= count_q);
   // R10: a response only arrives when a load is waiting for it
   a_r10_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid_i |-> (drop_q != '0 || filled_q < count_q));
   // R8: flush leaves the queue empty
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (count_q == '0 && !head_ready_o));
   // R9: the number of dropped responses is bounded by the depth
   a_r9_drop_bound: assert property (@(posedge clk) disable iff (!rst_n)
      drop_q <= CW'(DEPTH));

endmodule

// File: rtl/dd_load_ctrl.sv
module dd_load_ctrl
   import dd_load_pkg::*;
#(
   parameter int unsigned DEPTH = 2,
   localparam int unsigned CW   = cnt_width(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          issue_valid_i,
   input  logic          drain_valid_i,
   input  logic [CW-1:0] count_i,
   input  logic          head_ready_i,
   input  logic          drop_busy_i,
   output logic          issue_ready_o,
   output logic          drain_ready_o,
   output logic          push_o,
   output logic          pop_o,
   output ret_src_e      ret_src_o
);

   logic full, empty, issue_fire, drain_fire;

   assign full  = (count_i == CW'(DEPTH));
   assign empty = (count_i == '0);

   // A full queue can take a new load only by retiring its head
   assign issue_ready_o = !flush_i && !drop_busy_i && (!full || head_ready_i);
   // Issue has priority over drain in the same cycle
   assign drain_ready_o = !flush_i && !issue_valid_i && !empty && head_ready_i;

   assign issue_fire = issue_valid_i && issue_ready_o;
   assign drain_fire = drain_valid_i && drain_ready_o;

   assign push_o = issue_fire;
   assign pop_o  = (issue_fire && full) || drain_fire;

   always_comb begin
      ret_src_o = RET_NONE;
      if (issue_fire && full) ret_src_o = RET_ISSUE;
      else if (drain_fire)    ret_src_o = RET_DRAIN;
   end

   // R6: a full queue with a waiting head takes no new load
   a_r6_stall_on_missing_data: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !head_ready_i) |-> !push_o);
   // R7: every retirement finds data at the head
   a_r7_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      pop_o |-> head_ready_i);
   // R9: no load is started while flushed responses are pending
   a_r9_no_issue_while_dropping: assert property (@(posedge clk) disable iff (!rst_n)
      drop_busy_i |-> !push_o);
   // R8: flush and issue never share a cycle
   a_r8_flush_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !push_o && !pop_o);

endmodule

// File: rtl/dd_load_wb.sv
module dd_load_wb
   import dd_load_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_AW = 5,
   parameter bit          WB_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ret_src_e          ret_src_i,
   input  logic [REG_AW-1:0] issue_dest_i,
   input  logic [REG_AW-1:0] drain_dest_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              we_o,
   output logic [REG_AW-1:0] waddr_o,
   output logic [DATA_W-1:0] wdata_o
);

   logic              we_c;
   logic [REG_AW-1:0] waddr_c;

   assign we_c    = (ret_src_i != RET_NONE);
   assign waddr_c = (ret_src_i == RET_DRAIN) ? drain_dest_i : issue_dest_i;

   if (WB_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            we_o    <= 1'b0;
            waddr_o <= '0;
            wdata_o <= '0;
         end else begin
            we_o <= we_c;
            if (we_c) begin
               waddr_o <= waddr_c;
               wdata_o <= data_i;
            end
         end
      end
   end else begin : g_comb
      assign we_o    = we_c;
      assign waddr_o = waddr_c;
      assign wdata_o = data_i;
   end

endmodule

// File: rtl/dd_load_unit.sv
module dd_load_unit
   import dd_load_pkg::*;
#(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_AW = 5,
   parameter int unsigned DEPTH  = 2,
   parameter bit          WB_REG = 1'b1,
   localparam int unsigned CW    = cnt_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              issue_valid_i,
   input  logic [ADDR_W-1:0] issue_addr_i,
   input  logic [REG_AW-1:0] issue_dest_i,
   output logic              issue_ready_o,
   input  logic              drain_valid_i,
   input  logic [REG_AW-1:0] drain_dest_i,
   output logic              drain_ready_o,
   output logic              mem_req_valid_o,
   output logic [ADDR_W-1:0] mem_req_addr_o,
   input  logic              mem_rsp_valid_i,
   input  logic [DATA_W-1:0] mem_rsp_data_i,
   output logic              rf_we_o,
   output logic [REG_AW-1:0] rf_waddr_o,
   output logic [DATA_W-1:0] rf_wdata_o
);

   initial begin : p_param_check
      assert (DEPTH >= 1 && DEPTH <= 16) else $fatal(1, "DEPTH out of range");
      assert (ADDR_W >= 1 && DATA_W >= 1 && REG_AW >= 1)
         else $fatal(1, "widths must be positive");
   end

   logic [CW-1:0]     count;
   logic              head_ready, drop_busy, push, pop;
   logic [DATA_W-1:0] head_data;
   ret_src_e          ret_src;

   dd_load_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush_i       (flush_i),
      .issue_valid_i (issue_valid_i),
      .drain_valid_i (drain_valid_i),
      .count_i       (count),
      .head_ready_i  (head_ready),
      .drop_busy_i   (drop_busy),
      .issue_ready_o (issue_ready_o),
      .drain_ready_o (drain_ready_o),
      .push_o        (push),
      .pop_o         (pop),
      .ret_src_o     (ret_src)
   );

   dd_load_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_queue (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush_i      (flush_i),
      .push_i       (push),
      .pop_i        (pop),
      .rsp_valid_i  (mem_rsp_valid_i),
      .rsp_data_i   (mem_rsp_data_i),
      .count_o      (count),
      .head_ready_o (head_ready),
      .head_data_o  (head_data),
      .drop_busy_o  (drop_busy)
   );

   dd_load_wb #(.DATA_W(DATA_W), .REG_AW(REG_AW), .WB_REG(WB_REG)) u_wb (
      .clk          (clk),
      .rst_n        (rst_n),
      .ret_src_i    (ret_src),
      .issue_dest_i (issue_dest_i),
      .drain_dest_i (drain_dest_i),
      .data_i       (head_data),
      .we_o         (rf_we_o),
      .waddr_o      (rf_waddr_o),
      .wdata_o      (rf_wdata_o)
   );

   assign mem_req_valid_o = push;
   assign mem_req_addr_o  = issue_addr_i;

   // R3: a retirement by issue only happens with a full queue
   a_r3_issue_retire_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_src == RET_ISSUE) |-> (count == CW'(DEPTH)));
   // R2: a memory request never coexists with a flush
   a_r2_no_req_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |-> !mem_req_valid_o);

endmodule

// File: tb/test_dd_load_unit.sv
`timescale 1ns/1ps
module test_dd_load_unit;

   localparam int AW = 16, DW = 32, RW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic flush_i = 0, issue_valid_i = 0, drain_valid_i = 0;
   logic [AW-1:0] issue_addr_i = '0;
   logic [RW-1:0] issue_dest_i = '0, drain_dest_i = '0;
   logic issue_ready_o, drain_ready_o, mem_req_valid_o, mem_rsp_valid_i = 0;
   logic [AW-1:0] mem_req_addr_o;
   logic [DW-1:0] mem_rsp_data_i = '0, rf_wdata_o;
   logic rf_we_o;
   logic [RW-1:0] rf_waddr_o;

   always #4 clk = ~clk;   // 125 MHz

   dd_load_unit i_dd_load_unit (.*);

   int checks = 0, failures = 0, cyc = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
      return {a ^ 16'hC3A5, a * 16'd7 + 16'd1};
   endfunction

   // Memory model: in order, random latency, can be held
   bit hold_rsp = 0;
   logic [31:0] rng = 32'h1234_5678;
   logic [AW-1:0] pend_addr [16];
   int pend_due [16];
   int pend_wr = 0, pend_rd = 0;

   // Scoreboard of expected register writes
   logic [RW-1:0] exp_dest [256];
   logic [DW-1:0] exp_data [256];
   string exp_req [256];
   int exp_wr = 0, exp_rd = 0;

   // Reference queue of queued addresses
   logic [AW-1:0] mq [2];
   int mq_n = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         // R2: request mirrors an accepted issue
         if (issue_valid_i && issue_ready_o) begin
            check(mem_req_valid_o && mem_req_addr_o == issue_addr_i, "R2",
                  {mem_req_valid_o, mem_req_addr_o}, {1'b1, issue_addr_i});
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            pend_addr[pend_wr % 16] = issue_addr_i;
            pend_due[pend_wr % 16]  = cyc + 1 + int'(rng % 6);
            pend_wr++;
         end else if (mem_req_valid_o)
            check(0, "R2", 1, 0);
         if (rf_we_o) begin
            if (exp_rd == exp_wr) check(0, "R3 unexpected write", rf_waddr_o, 0);
            else begin
               check(rf_waddr_o == exp_dest[exp_rd % 256] && rf_wdata_o == exp_data[exp_rd % 256],
                     exp_req[exp_rd % 256], {rf_waddr_o, rf_wdata_o},
                     {exp_dest[exp_rd % 256], exp_data[exp_rd % 256]});
               exp_rd++;
            end
         end
         if (!hold_rsp && pend_rd < pend_wr && pend_due[pend_rd % 16] <= cyc) begin
            mem_rsp_valid_i = 1;
            mem_rsp_data_i  = memf(pend_addr[pend_rd % 16]);
            pend_rd++;
         end else begin
            mem_rsp_valid_i = 0;
         end
      end
   end

   task automatic expect_wr(input logic [RW-1:0] d, input logic [AW-1:0] a, input string r);
      exp_dest[exp_wr % 256] = d;
      exp_data[exp_wr % 256] = memf(a);
      exp_req[exp_wr % 256]  = r;
      exp_wr++;
   endtask

   task automatic do_issue(input logic [AW-1:0] a, input logic [RW-1:0] d);
      @(posedge clk); #1;
      issue_valid_i = 1; issue_addr_i = a; issue_dest_i = d;
      @(negedge clk);
      while (!issue_ready_o) @(negedge clk);
      if (mq_n == 2) begin
         expect_wr(d, mq[0], "R4/R11");   // load N-2 lands in dest of load N
         mq[0] = mq[1]; mq[1] = a;
      end else begin
         mq[mq_n] = a; mq_n++;             // R3: dest ignored
      end
      @(posedge clk); #1;
      issue_valid_i = 0;
   endtask

   task automatic do_drain(input logic [RW-1:0] d);
      @(posedge clk); #1;
      drain_valid_i = 1; drain_dest_i = d;
      @(negedge clk);
      while (!drain_ready_o) @(negedge clk);
      expect_wr(d, mq[0], "R7");
      mq[0] = mq[1]; mq_n--;
      @(posedge clk); #1;
      drain_valid_i = 0;
   endtask

   task automatic do_flush();
      @(posedge clk); #1;
      flush_i = 1;
      @(posedge clk); #1;
      flush_i = 0;
      mq_n = 0;
   endtask

   // op: 0 issue, 1 drain, 2 flush ; {op[1:0], addr[15:0], dest[4:0]}
   localparam int NV = 18;
   localparam logic [22:0] VEC [NV] = '{
      {2'd0, 16'h0100, 5'd31}, {2'd0, 16'h0104, 5'd30}, {2'd0, 16'h0108, 5'd1},
      {2'd0, 16'h010C, 5'd2},  {2'd0, 16'h0110, 5'd3},  {2'd0, 16'h0200, 5'd4},
      {2'd0, 16'h01F0, 5'd5},  {2'd0, 16'h01E0, 5'd6},  {2'd0, 16'h01E0, 5'd7},
      {2'd1, 16'h0000, 5'd8},  {2'd0, 16'hBEEF, 5'd9},  {2'd0, 16'h0003, 5'd10},
      {2'd0, 16'h7FFF, 5'd11}, {2'd2, 16'h0000, 5'd0},  {2'd0, 16'h0040, 5'd12},
      {2'd0, 16'h0080, 5'd13}, {2'd0, 16'h00C0, 5'd14}, {2'd1, 16'h0000, 5'd15}
   };

   initial begin
      // R1: reset state
      #20;
      check(issue_ready_o == 1 && drain_ready_o == 0 && mem_req_valid_o == 0 && rf_we_o == 0,
            "R1", {issue_ready_o, drain_ready_o, mem_req_valid_o, rf_we_o}, 4'b1000);
      @(posedge clk); #1; rst_n = 1;

      for (int i = 0; i < NV; i++) begin
         case (VEC[i][22:21])
            2'd0: do_issue(VEC[i][20:5], VEC[i][4:0]);
            2'd1: do_drain(VEC[i][4:0]);
            default: do_flush();
         endcase
      end
      while (mq_n > 0) do_drain(5'd20);

      // R7: drain with empty queue is ignored
      @(posedge clk); #1; drain_valid_i = 1; drain_dest_i = 5'd21;
      repeat (3) begin
         @(negedge clk);
         check(drain_ready_o == 0 && rf_we_o == 0, "R7 empty drain",
               {drain_ready_o, rf_we_o}, 0);
      end
      @(posedge clk); #1; drain_valid_i = 0;

      // R6: stall on missing oldest data
      hold_rsp = 1;
      do_issue(16'h0A00, 5'd0);
      do_issue(16'h0A10, 5'd0);
      @(posedge clk); #1; issue_valid_i = 1; issue_addr_i = 16'h0A20; issue_dest_i = 5'd22;
      repeat (4) begin
         @(negedge clk);
         check(issue_ready_o == 0 && mem_req_valid_o == 0, "R6 stall",
               {issue_ready_o, mem_req_valid_o}, 0);
      end
      // R7: drain blocked while issue is presented
      check(drain_ready_o == 0, "R7 issue priority", drain_ready_o, 0);
      @(posedge clk); #1; issue_valid_i = 0;
      hold_rsp = 0;
      do_issue(16'h0A20, 5'd22);
      do_issue(16'h0A30, 5'd23);

      // R8/R9: flush with two loads in flight
      hold_rsp = 1;
      repeat (8) @(posedge clk);
      do_issue(16'h0B00, 5'd24);  // still queued, data held
      do_flush();
      @(negedge clk);
      check(issue_ready_o == 0, "R9 drop pending", issue_ready_o, 0);
      hold_rsp = 0;
      do_issue(16'h0C00, 5'd25);
      do_issue(16'h0C40, 5'd26);
      do_issue(16'h0C80, 5'd27);
      do_issue(16'h0CC0, 5'd28);
      while (mq_n > 0) do_drain(5'd29);

      // R10: burst with random latencies
      for (int k = 0; k < 20; k++) do_issue(16'h3000 + 16'(k * 37), 5'(k));
      while (mq_n > 0) do_drain(5'd19);

      repeat (20) @(posedge clk);
      @(negedge clk);
      check(exp_rd == exp_wr, "R4 all writes seen", exp_rd, exp_wr);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      failures++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule